// File: doc/BRIEF.md
# Dual-Mode Baud Tick Generator

This block derives a 16x-oversampling strobe for an asynchronous serial port from a fast peripheral clock. It has two engines behind one output. The integer engine is a down-counter: it reloads from the programmed word and fires each time it wraps, so one tick comes out every `reload` clocks. The fractional engine is a phase accumulator of the same width as the programmed word: it adds the word on every clock and fires on carry-out, so the tick rate is `clk * word / 2^W`.

Software sets the word to `f_clk / (16 * baud)` for integer operation, or to `round(baud * 16 * 2^16 / f_clk)` for fractional operation. Integer operation suits rates below 19200. Fractional operation suits 19200 and above, where the integer divisor gets small and its rounding error grows. The intended sequence is to drop the run input, load a new word, then raise run again. Only the engine that is selected runs. The other engine is held at zero, as are both engines while run is low. The output is a registered single-clock pulse.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_ni is low, tick_o is 0. After reset both engines start from zero.
- R2: With frac_mode_i=0 and reload_i=N (N>=1) held, raising run_i gives tick_o=1 after the first rising edge of run, then every N clocks after that, and 0 otherwise.
- R3: In integer mode a reload_i of 0 acts as divide-by-one, so tick_o is 1 on every clock while run.
- R4: With frac_mode_i=1 and increment reload_i=I held, tick_o after the k-th rising edge of run (k>=1) is 1 exactly when floor(k*I/2^W) > floor((k-1)*I/2^W), where W is the reload width.
- R5: In fractional mode an increment of 0 never produces a tick.
- R6: While run_i is low, tick_o is 0 from the next clock on and both engines are cleared. A later rise of run_i restarts the phase as in R2 and R4.
- R7: In integer mode, a change of reload_i during a countdown does not alter the countdown in progress. The new value sets the length of the period that starts at the next wrap.
- R8: In fractional mode, a change of reload_i is used from the very next accumulation, with no reset of the phase.
- R9: In integer mode with reload_i>=2, every tick lasts exactly one clock.
- R10: frac_mode_i=1 selects the accumulator and frac_mode_i=0 selects the down-counter. The unselected engine is held at zero, so a mode switch starts the newly selected engine from zero phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Generator enable |
| frac_mode_i | input | 1 | 1 = fractional accumulator, 0 = integer divider |
| reload_i | input | RELOAD_W | Divisor (integer mode) or phase increment (fractional mode) |
| tick_o | output | 1 | Single-clock oversample strobe |

## Verification
The bench builds the block with RELOAD_W=8. This makes it possible to sweep every divisor from 0 to 255 over two full periods, and every increment from 0 to 255 over one full accumulator revolution of 256 clocks. In that revolution each edge is compared against the floor-difference formula, so the exact placement of every tick is checked and not only the count. The small width also keeps mid-period reload changes, increment changes and mode switches short enough to model cycle by cycle.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } tick_mode_e;
endpackage

// File: rtl/baud_int_div.sv
module baud_int_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] reload_m1;

  // zero reload behaves as divide-by-one
  assign reload_m1 = (reload_i == '0) ? '0 : reload_i - W'(1);
  assign tick_o    = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q == '0)     cnt_q <= reload_m1;
    else                      cnt_q <= cnt_q - W'(1);
  end

  p_hold_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  p_single_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && reload_i >= W'(2)) |=> !tick_o);
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] inc_i,
  output logic         tick_o
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  acc_q;
  logic [SW-1:0] sum;

  assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
  assign tick_o = en_i && sum[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= sum[W-1:0];
  end

  p_hold_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0));

  p_wrap_residue_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_o) |=> (acc_q < $past(inc_i)));

  p_zero_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == '0) |-> !tick_o);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned RELOAD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                frac_mode_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                tick_o
);
  tick_mode_e mode;
  logic       int_en, frac_en;
  logic       int_tick, frac_tick;
  logic       tick_q;

  assign mode    = tick_mode_e'(frac_mode_i);
  assign int_en  = run_i && (mode == MODE_INT);
  assign frac_en = run_i && (mode == MODE_FRAC);

  baud_int_div #(.W(RELOAD_W)) u_int (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (int_en),
    .reload_i (reload_i),
    .tick_o   (int_tick)
  );

  baud_frac_acc #(.W(RELOAD_W)) u_frac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (frac_en),
    .inc_i  (reload_i),
    .tick_o (frac_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= (mode == MODE_FRAC) ? frac_tick : int_tick;
  end

  assign tick_o = tick_q;

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tick_o);

  p_engines_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(int_tick && frac_tick));

  always_comb begin
    if (!rst_ni) p_reset_low_r1: assert (tick_o == 1'b0);
  end
endmodule

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;
  localparam int W   = 8;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         run = 1'b0;
  logic         frac = 1'b0;
  logic [W-1:0] reload = '0;
  logic         tick;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  baud_tick_gen #(.RELOAD_W(W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .frac_mode_i (frac),
    .reload_i    (reload),
    .tick_o      (tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stop_gen();
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int errs, first_bad_i, first_bad_v;
    // R1: reset
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R1 reset", tick, 0);
    rst_ni = 1'b1;

    // R6: idle in both modes
    errs = 0;
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      frac = m[0];
      reload = 8'd1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (tick) errs++;
      end
    end
    chk(errs == 0, "R6 idle", errs, 0);

    // R2 R3 R9: integer sweep, every divisor, two periods
    for (int n = 0; n < MOD; n++) begin
      int neff;
      neff = (n == 0) ? 1 : n;
      stop_gen();
      frac = 1'b0;
      reload = W'(n);
      run = 1'b1;
      errs = 0; first_bad_i = 0; first_bad_v = 0;
      for (int i = 1; i <= 2 * neff + 1; i++) begin
        @(negedge clk);
        if (tick != (((i - 1) % neff) == 0)) begin
          if (errs == 0) begin first_bad_i = i; first_bad_v = tick; end
          errs++;
        end
      end
      chk(errs == 0, (n == 0) ? "R3 zero divisor" : "R2 integer period",
          first_bad_i, n);
    end

    // R4 R5: fractional sweep, every increment, full revolution
    for (int inc = 0; inc < MOD; inc++) begin
      stop_gen();
      frac = 1'b1;
      reload = W'(inc);
      run = 1'b1;
      errs = 0; first_bad_i = 0;
      for (int k = 1; k <= MOD; k++) begin
        bit e;
        @(negedge clk);
        e = ((k * inc) / MOD) != (((k - 1) * inc) / MOD);
        if (tick != e) begin
          if (errs == 0) first_bad_i = k;
          errs++;
        end
      end
      chk(errs == 0, (inc == 0) ? "R5 zero increment" : "R4 fractional phase",
          first_bad_i, 0);
    end

    // R7: reload change mid-countdown
    stop_gen();
    frac = 1'b0;
    reload = 8'd10;
    run = 1'b1;
    errs = 0; first_bad_i = 0;
    for (int i = 1; i <= 24; i++) begin
      bit e;
      @(negedge clk);
      e = (i == 1) || (i == 11) || (i == 15) || (i == 19) || (i == 23);
      if (tick != e) begin
        if (errs == 0) first_bad_i = i;
        errs++;
      end
      if (i == 3) reload = 8'd4;
    end
    chk(errs == 0, "R7 reload at wrap", first_bad_i, 0);

    // R8: increment change used on the next accumulation
    stop_gen();
    frac = 1'b1;
    begin
      int acc_m;
      acc_m = 0;
      errs = 0; first_bad_i = 0;
      run = 1'b1;
      for (int i = 1; i <= 40; i++) begin
        int cur, s;
        cur = (i <= 5) ? 200 : 37;
        reload = W'(cur);
        @(negedge clk);
        s = acc_m + cur;
        if (tick != (s >= MOD)) begin
          if (errs == 0) first_bad_i = i;
          errs++;
        end
        acc_m = s % MOD;
      end
      chk(errs == 0, "R8 increment change", first_bad_i, 0);
    end

    // R10: mode switch restarts the selected engine from zero
    stop_gen();
    frac = 1'b0;
    reload = 8'd5;
    run = 1'b1;
    repeat (7) @(negedge clk);
    frac = 1'b1;
    reload = 8'd64;
    errs = 0; first_bad_i = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (tick != ((k % 4) == 0)) begin
        if (errs == 0) first_bad_i = k;
        errs++;
      end
    end
    chk(errs == 0, "R10 switch to fractional", first_bad_i, 0);
    frac = 1'b0;
    reload = 8'd3;
    errs = 0; first_bad_i = 0;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (tick != (((k - 1) % 3) == 0)) begin
        if (errs == 0) first_bad_i = k;
        errs++;
      end
    end
    chk(errs == 0, "R10 switch to integer", first_bad_i, 0);

    // R6: dropping run silences the next cycle
    stop_gen();
    frac = 1'b0;
    reload = 8'd1;
    run = 1'b1;
    repeat (4) @(negedge clk);
    chk(tick == 1'b1, "R6 running before drop", tick, 1);
    run = 1'b0;
    @(negedge clk);
    chk(tick == 1'b0, "R6 drop run", tick, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule